// File: doc/BRIEF.md
# Prioritized Two-Class Interrupt Controller

This block gathers 32 interrupt sources, holds a pending bit for each, and raises one of two request outputs: one for the normal class and one for the fast class. Each line has its own configuration. It sets the sensitivity (edge or level), a 5-bit priority where 0 is most urgent, and the class the line belongs to. A mask register keeps chosen lines from reaching either output.

Software reaches the block through a small word-addressed register port. Accesses are offered on a valid/ready channel, and read results come back on a valid/ready response channel. Only one response can be outstanding. While a read result waits, `acc_ready` is low, so new accesses are held off until the consumer takes the result. A write takes effect on the edge that accepts it and produces no response.

When an output asserts, the block records which line won arbitration for that class. Reading the class's code register returns that line number and acknowledges the line if it is edge-sensitive. Each output then stays high until software re-arms it through the control register.

Top module: `lvl_edge_intc`

## Requirements
- R1: After reset, all pending bits are 0 and every line's configuration reads 0. The mask register (offset 0x00 is pending, 0x04 is mask) reads 0xFFFFFFFF. Both outputs are low, both code registers read 0, and both outputs are armed.
- R2: A line with sensitivity bit 0 (edge) becomes pending once per new assertion of its source (0 to 1). While the source stays high it does not pend again, and releasing the source leaves the pending bit set.
- R3: A line with sensitivity bit 1 (level) becomes pending whenever its source is high and the line is not already pending. A release of its source clears its pending bit on the next edge.
- R4: A write to offset 0x00 ANDs the pending bits with the written word. The exception is a level line whose source is still high: it keeps its bit.
- R5: Mask bit 1 means masked. The normal output (class bit 0) and the fast output (class bit 1) each consider only unmasked pending lines of their own class.
- R6: An armed output rises on the clock edge after an eligible line is pending; that edge also disarms it. It then stays high, with its recorded code unchanged, until re-armed, even if the line is cleared.
- R7: A write to offset 0x18 uses bit 0 for the normal output and bit 1 for the fast output. Each set bit drops that output on the accepting edge and re-arms it, so the output can fire again from the next edge. Reads of 0x18 return 0.
- R8: Offsets 0x10 (normal) and 0x14 (fast) read the line recorded when that output last fired. The lowest priority value wins; among equal priorities the higher line number wins.
- R9: A read of 0x10 or 0x14 clears the recorded line's pending bit if that line is edge-sensitive. A level line is unaffected.
- R10: The configuration word for line n is at offset 0x1C + 4*n. Bits [6:2] are the priority, bit 1 the sensitivity and bit 0 the class. A read returns the stored fields.
- R11: A write to offset 0x9C sets the pending bit of only the lowest-numbered line whose bit is set in the written word. Reads of 0x9C return 0.
- R12: Offsets not named above, and offsets not a multiple of 4, read 0, and writes to them change nothing.
- R13: A read result appears on `rsp_valid` one edge after acceptance. It holds with stable data until `rsp_ready`, and `acc_ready` stays low while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Interrupt sources, high = request active |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access can be accepted |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the register |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_rdata | output | 32 | Read result |
| irq_norm_o | output | 1 | Normal-class request |
| irq_fast_o | output | 1 | Fast-class request |

## Verification
A source sampled high on one edge shows in the pending bits after that edge, and the class output rises on the following edge. Register writes act on their accepting edge, so an unmask or re-arm shows on the output one edge later. A read result is valid one edge after acceptance. The bench drives on falling edges and samples outputs at falling edges counted from each stimulus, checking output levels exactly where the edge count says they change. Read results are queued as expectations by the driver and compared by a monitor when the response handshake completes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  parameter int unsigned PRIO_W = 5;
  localparam int unsigned CFG_W = PRIO_W + 2;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              fast;
  } line_cfg_t;

  localparam logic [7:0] OFS_PEND   = 8'h00;
  localparam logic [7:0] OFS_MASK   = 8'h04;
  localparam logic [7:0] OFS_CODE_N = 8'h10;
  localparam logic [7:0] OFS_CODE_F = 8'h14;
  localparam logic [7:0] OFS_CTRL   = 8'h18;
  localparam logic [7:0] OFS_CFG0   = 8'h1C;
  localparam logic [7:0] OFS_SWREQ  = 8'h9C;
endpackage

// File: rtl/intc_line.sv
module intc_line
  import intc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src_i,
  input  logic      cfg_we,
  input  line_cfg_t cfg_wd,
  input  logic      clr_we,
  input  logic      clr_keep,
  input  logic      sw_set,
  input  logic      ack_clr,
  output logic      pend_o,
  output line_cfg_t cfg_o
);
  logic      pend_q, seen_q;
  line_cfg_t cfg_q;
  logic      rise_hw, release_ev, clr_now;

  always_comb begin
    rise_hw    = src_i & ~pend_q & (cfg_q.level | ~seen_q);
    release_ev = seen_q & ~src_i;
    clr_now    = (clr_we & ~clr_keep & ~(cfg_q.level & seen_q))
               | (ack_clr & ~cfg_q.level)
               | (release_ev & cfg_q.level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      seen_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      seen_q <= src_i;
      if (cfg_we) cfg_q <= cfg_wd;
      if (rise_hw | sw_set) pend_q <= 1'b1;
      else if (clr_now)     pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign cfg_o  = cfg_q;

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.level && seen_q && src_i |=> pend_q);  // R3
  AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.level && seen_q && !src_i && !sw_set |=> !pend_q);  // R3
  AST_EDGE_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.level && seen_q && src_i && !pend_q && !sw_set |=> !pend_q);  // R2
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  localparam int unsigned CODE_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0]             cand_i,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
  output logic                           any_o,
  output logic [CODE_W-1:0]              code_o
);
  logic              found;
  logic [PRIO_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    best   = '0;
    code_o = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (cand_i[i] && (!found || prio_i[i] <= best)) begin
        found  = 1'b1;
        best   = prio_i[i];
        code_o = CODE_W'(i);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rearm_i,
  output logic              out_o,
  output logic [CODE_W-1:0] code_o
);
  logic              fired_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      code_q  <= '0;
    end else if (rearm_i) begin
      fired_q <= 1'b0;
    end else if (!fired_q && any_i) begin
      fired_q <= 1'b1;
      code_q  <= code_i;
    end
  end

  assign out_o  = fired_q;
  assign code_o = code_q;

  AST_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_o && any_i && !rearm_i |=> out_o);  // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_o && !rearm_i |=> out_o && $stable(code_o));  // R6
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> !out_o);  // R7
endmodule

// File: rtl/lvl_edge_intc.sv
module lvl_edge_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] src_i,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  localparam int unsigned CODE_W   = $clog2(N_LINES);
  localparam int unsigned N_CLASS  = 2;
  localparam int unsigned CFG_LAST = int'(OFS_CFG0) + 4 * (N_LINES - 1);

  logic                          wr, rd;
  logic                          hit_pend, hit_mask, hit_code_n, hit_code_f;
  logic                          hit_ctrl, hit_swreq, is_cfg;
  logic [CODE_W-1:0]             cfg_idx;
  logic [N_LINES-1:0]            mask_q, pend, cls, sw_low, ack_vec;
  line_cfg_t                     cfg_arr [N_LINES];
  logic [N_LINES-1:0][PRIO_W-1:0] prio;
  line_cfg_t                     cfg_wd;
  logic [N_LINES-1:0]            cand   [N_CLASS];
  logic [N_CLASS-1:0]            any_c, fired, rearm;
  logic [CODE_W-1:0]             win    [N_CLASS];
  logic [CODE_W-1:0]             code_c [N_CLASS];
  logic [DATA_W-1:0]             rd_mux;

  // access decode
  always_comb begin
    wr         = acc_valid & acc_ready & acc_write;
    rd         = acc_valid & acc_ready & ~acc_write;
    hit_pend   = acc_addr == ADDR_W'(OFS_PEND);
    hit_mask   = acc_addr == ADDR_W'(OFS_MASK);
    hit_code_n = acc_addr == ADDR_W'(OFS_CODE_N);
    hit_code_f = acc_addr == ADDR_W'(OFS_CODE_F);
    hit_ctrl   = acc_addr == ADDR_W'(OFS_CTRL);
    hit_swreq  = acc_addr == ADDR_W'(OFS_SWREQ);
    is_cfg     = (int'(acc_addr) >= int'(OFS_CFG0)) && (int'(acc_addr) <= CFG_LAST)
               && (acc_addr[1:0] == 2'b00);
    cfg_idx    = CODE_W'((acc_addr - ADDR_W'(OFS_CFG0)) >> 2);
    cfg_wd     = line_cfg_t'(acc_wdata[CFG_W-1:0]);
    sw_low     = acc_wdata[N_LINES-1:0] & (~acc_wdata[N_LINES-1:0] + 1'b1);
    ack_vec    = '0;
    if (rd && hit_code_n) ack_vec = ack_vec | (N_LINES'(1) << code_c[0]);
    if (rd && hit_code_f) ack_vec = ack_vec | (N_LINES'(1) << code_c[1]);
    for (int c = 0; c < int'(N_CLASS); c++) rearm[c] = wr & hit_ctrl & acc_wdata[c];
  end

  // per-line state
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    intc_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_i[g]),
      .cfg_we  (wr && is_cfg && (cfg_idx == CODE_W'(g))),
      .cfg_wd  (cfg_wd),
      .clr_we  (wr && hit_pend),
      .clr_keep(acc_wdata[g]),
      .sw_set  (wr && hit_swreq && sw_low[g]),
      .ack_clr (ack_vec[g]),
      .pend_o  (pend[g]),
      .cfg_o   (cfg_arr[g])
    );
    assign prio[g] = cfg_arr[g].prio;
    assign cls[g]  = cfg_arr[g].fast;
  end

  assign cand[0] = pend & ~mask_q & ~cls;
  assign cand[1] = pend & ~mask_q & cls;

  // arbitration and output per class
  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    intc_pick #(.N_LINES(N_LINES)) u_pick (
      .cand_i(cand[c]),
      .prio_i(prio),
      .any_o (any_c[c]),
      .code_o(win[c])
    );
    intc_gate #(.CODE_W(CODE_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .any_i  (any_c[c]),
      .code_i (win[c]),
      .rearm_i(rearm[c]),
      .out_o  (fired[c]),
      .code_o (code_c[c])
    );
  end

  assign irq_norm_o = fired[0];
  assign irq_fast_o = fired[1];

  // mask register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mask_q <= '1;
    else if (wr && hit_mask)  mask_q <= acc_wdata[N_LINES-1:0];
  end

  // read data select
  always_comb begin
    rd_mux = '0;
    if (hit_pend)        rd_mux = DATA_W'(pend);
    else if (hit_mask)   rd_mux = DATA_W'(mask_q);
    else if (hit_code_n) rd_mux = DATA_W'(code_c[0]);
    else if (hit_code_f) rd_mux = DATA_W'(code_c[1]);
    else if (is_cfg)     rd_mux = DATA_W'(cfg_arr[cfg_idx]);
  end

  // response channel, one result outstanding
  assign acc_ready = ~rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));  // R13
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !acc_ready);  // R13
endmodule

// File: tb/sim_lvl_edge_intc.sv
`timescale 1ns/1ps
module sim_lvl_edge_intc;
  localparam logic [7:0] A_PEND = 8'h00, A_MASK = 8'h04, A_CN = 8'h10, A_CF = 8'h14;
  localparam logic [7:0] A_CTRL = 8'h18, A_SW = 8'h9C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_ready, rsp_valid, irq_norm, irq_fast;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  lvl_edge_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_norm_o(irq_norm), .irq_fast_o(irq_fast)
  );

  function automatic logic [7:0] cfg_a(input int n);
    return 8'(8'h1C + 4 * n);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // driver: push the expectation, then issue the read
  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor: pop and compare on each completed response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R13 actual=%h expected=no response", rsp_rdata);
      end else begin
        check(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(32'(irq_norm), 0, "R1 norm out");
    check(32'(irq_fast), 0, "R1 fast out");
    bus_rd(A_PEND, 32'h0, "R1 pending");
    bus_rd(A_MASK, 32'hFFFF_FFFF, "R1 mask");
    bus_rd(cfg_a(5), 32'h0, "R1 config");
    bus_rd(A_CN, 32'h0, "R1 code normal");
    bus_rd(A_CF, 32'h0, "R1 code fast");
    // R10 config fields
    bus_wr(cfg_a(31), 32'h7F);
    bus_rd(cfg_a(31), 32'h7F, "R10 readback");
    bus_wr(cfg_a(31), 32'h0);
    bus_rd(cfg_a(31), 32'h0, "R10 rewrite");
    // R2 edge line 3
    src[3] = 1'b1; tick(1);
    bus_rd(A_PEND, 32'h8, "R2 edge set");
    bus_wr(A_PEND, 32'hFFFF_FFF7); tick(2);
    bus_rd(A_PEND, 32'h0, "R2 no retrigger while held");
    src[3] = 1'b0; tick(1); src[3] = 1'b1; tick(1); src[3] = 1'b0; tick(1);
    bus_rd(A_PEND, 32'h8, "R2 release keeps pending");
    bus_wr(A_PEND, 32'h0);
    bus_rd(A_PEND, 32'h0, "R4 edge cleared");
    // R3 level line 7
    bus_wr(cfg_a(7), 32'h02);
    src[7] = 1'b1; tick(1);
    bus_rd(A_PEND, 32'h80, "R3 level set");
    bus_wr(A_PEND, 32'h0);
    bus_rd(A_PEND, 32'h80, "R4 level clear blocked");
    src[7] = 1'b0; tick(1);
    bus_rd(A_PEND, 32'h0, "R3 release clears");
    // R5 R6 R8 R9 normal class: lines 4 and 9, equal priority 3
    bus_wr(cfg_a(4), 32'h0C);
    bus_wr(cfg_a(9), 32'h0C);
    src[4] = 1'b1; src[9] = 1'b1; tick(3);
    check(32'(irq_norm), 0, "R5 masked lines quiet");
    bus_wr(A_MASK, 32'hFFFF_FDEF);
    check(32'(irq_norm), 0, "R6 not before next edge");
    tick(1);
    check(32'(irq_norm), 1, "R6 fires");
    check(32'(irq_fast), 0, "R5 other class quiet");
    bus_rd(A_CN, 32'd9, "R8 tie goes to higher line");
    bus_rd(A_PEND, 32'h10, "R9 edge acked");
    check(32'(irq_norm), 1, "R6 stays high");
    bus_wr(A_CTRL, 32'h1);
    check(32'(irq_norm), 0, "R7 rearm drops output");
    tick(1);
    check(32'(irq_norm), 1, "R7 refires");
    bus_rd(A_CN, 32'd4, "R8 next winner");
    bus_rd(A_PEND, 32'h0, "R9 second ack");
    bus_wr(A_CTRL, 32'h1); tick(2);
    check(32'(irq_norm), 0, "R7 nothing pending");
    // fast class: line 12 edge prio 1, line 20 level prio 2
    bus_wr(cfg_a(12), 32'h05);
    bus_wr(cfg_a(20), 32'h0B);
    bus_wr(A_MASK, 32'hFFEF_EDEF);
    src[12] = 1'b1; src[20] = 1'b1; tick(3);
    check(32'(irq_fast), 1, "R5 fast fires");
    check(32'(irq_norm), 0, "R5 normal quiet");
    bus_rd(A_CF, 32'd12, "R8 lower priority value wins");
    bus_rd(A_PEND, 32'h0010_0000, "R9 edge cleared level kept");
    bus_rd(A_CF, 32'd12, "R6 code held until rearm");
    bus_wr(A_CTRL, 32'h2); tick(1);
    check(32'(irq_fast), 1, "R7 fast refires");
    bus_rd(A_CF, 32'd20, "R8 level winner");
    bus_rd(A_PEND, 32'h0010_0000, "R9 level not acked");
    src[20] = 1'b0; tick(1);
    bus_rd(A_PEND, 32'h0, "R3 level release");
    bus_wr(A_CTRL, 32'h2); tick(2);
    check(32'(irq_fast), 0, "R7 fast idle");
    // R11 software request
    bus_wr(A_SW, 32'h0000_0300);
    bus_rd(A_PEND, 32'h0000_0100, "R11 lowest bit only");
    bus_rd(A_SW, 32'h0, "R11 reads zero");
    check(32'(irq_norm), 0, "R5 line 8 masked");
    bus_wr(A_PEND, 32'h0);
    bus_rd(A_PEND, 32'h0, "R4 clear software request");
    // R12 undefined and unaligned offsets
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_rd(8'h0C, 32'h0, "R12 undefined read");
    bus_wr(8'h05, 32'h0);
    bus_rd(A_MASK, 32'hFFEF_EDEF, "R12 unaligned write ignored");
    bus_rd(8'hA0, 32'h0, "R12 beyond config");
    bus_rd(A_CTRL, 32'h0, "R7 control reads zero");
    bus_wr(8'h1D, 32'h7F);
    bus_rd(cfg_a(0), 32'h0, "R12 unaligned config ignored");
    // R13 back-pressure on the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    bus_rd(A_MASK, 32'hFFEF_EDEF, "R13 held read");
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({30'd0, rsp_valid, acc_ready}, 32'h2, "R13 valid held, ready low");
      check(rsp_rdata, held, "R13 data stable");
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    tick(4);
    check(32'(exp_q.size()), 0, "R13 all responses seen");
    finish_run();
  end
endmodule